// File: doc/BRIEF.md
# Flag-Aware Register Rename Table

This block renames the integer registers and the arithmetic condition flags of a small out-of-order core. Each micro-op that produces an integer result, flags, or both receives exactly one physical register. That register is wide enough to hold the result together with the six condition bits. Flags therefore have no storage of their own. The table keeps one slot per architectural register plus two flag-group slots, and each slot names a physical tag. The carry group is a single bit. The other group holds the remaining five flags. An increment-style op that leaves carry alone moves only the second pointer, so a later reader of carry does not wait for it.

A second copy of the slots follows retirement in program order. When a micro-op commits, its tag replaces the committed entries it wrote. A tag that no committed slot names any longer returns to the free pool. On a flush, the speculative slots are reloaded from the committed copy in a single cycle, and every in-flight tag becomes free again. The free pool is a bitmap of idle tags, and a new tag is always the lowest-numbered idle one. One micro-op is renamed per cycle. When an op needs a tag and none is idle, `ren_ready` drops.

Top module: `flag_rename_table`

## Requirements
- R1: After reset, architectural register i maps to tag i, and both flag-group pointers name tag 0.
- R2: The source tags `ren_src0_tag` and `ren_src1_tag`, and both flag-group tags, show the current speculative slots in the same cycle, with no register in between.
- R3: An accepted op that writes a destination register or any flag group takes exactly one tag, the lowest idle one. From the next cycle, its destination and every flag group it writes name that tag.
- R4: `ren_flag_wr` bit 1 selects the carry group and bit 0 selects the other five flags. Each group pointer moves only when its bit is set, and 2'b00 leaves both pointers alone.
- R5: An op that writes no destination and no flags has `ren_alloc` low and changes no slot.
- R6: When an op needs a tag and none is idle, `ren_ready` is low, and no slot changes.
- R7: A new tag is never named by the committed slots and is never still in flight.
- R8: On commit, the committed slots the op wrote take `cmt_tag`. A tag released by a commit can be allocated from the following cycle.
- R9: While `flush` is high, `ren_ready` is low. On the next cycle the speculative slots equal the committed slots, including any commit made in the flush cycle, and all tags that were in flight are idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Restore the speculative slots from the committed copy |
| ren_valid | input | 1 | A micro-op is offered for rename |
| ren_src0 | input | 3 | First source register |
| ren_src1 | input | 3 | Second source register |
| ren_dst_vld | input | 1 | The op writes a destination register |
| ren_dst | input | 3 | Destination register |
| ren_flag_wr | input | 2 | Flag groups written: bit 1 carry, bit 0 others |
| ren_ready | output | 1 | The offered op can be accepted this cycle |
| ren_alloc | output | 1 | A tag is taken this cycle |
| ren_src0_tag | output | 5 | Tag for the first source |
| ren_src1_tag | output | 5 | Tag for the second source |
| ren_carry_tag | output | 5 | Tag holding the newest carry |
| ren_rest_tag | output | 5 | Tag holding the newest other flags |
| ren_new_tag | output | 5 | Tag given to the op |
| cmt_valid | input | 1 | The oldest op retires |
| cmt_dst_vld | input | 1 | The retiring op wrote a destination |
| cmt_dst | input | 3 | The retiring op's destination |
| cmt_flag_wr | input | 2 | The retiring op's flag groups, same encoding |
| cmt_tag | input | 5 | The retiring op's tag |

## Verification
A speculative slot that is wrong shows up in the next cycle as a wrong source or flag tag on any lookup of that register or group. A partial-flag writer that moves the carry pointer wrongly shows up on the very next carry lookup. A wrong free-pool state shows up either as a reused tag or as `ren_ready` at the wrong level on the first allocation after a commit or flush. The bench keeps a reference model of both slot copies and the in-flight set, and compares every lookup, ready level and new tag in every cycle, so each of these faults is caught within one cycle of the first access that can see it.

// File: rtl/frt_pkg.sv
package frt_pkg;
   // Bit positions inside a flag-write mask.
   localparam int FW_CARRY = 1;
   localparam int FW_REST  = 0;

   typedef enum logic [1:0] {
      FW_NONE  = 2'b00,
      FW_OTHER = 2'b01,
      FW_CONLY = 2'b10,
      FW_ALL   = 2'b11
   } flag_wr_e;
endpackage

// File: rtl/frt_alias_state.sv
module frt_alias_state
   import frt_pkg::*;
#(
   parameter int NUM_ARCH = 8,
   parameter int TAG_W    = 5,
   parameter int ARCH_W   = $clog2(NUM_ARCH),
   parameter int NSLOT    = NUM_ARCH + 2
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         upd_en,
   input  logic                         upd_dst_vld,
   input  logic [ARCH_W-1:0]            upd_dst,
   input  logic [1:0]                   upd_flags,
   input  logic [TAG_W-1:0]             upd_tag,
   input  logic                         load_en,
   input  logic [NSLOT-1:0][TAG_W-1:0]  load_img,
   output logic [NSLOT-1:0][TAG_W-1:0]  img
);
   localparam int C_SLOT = NUM_ARCH;

   logic [NSLOT-1:0][TAG_W-1:0] nxt_img;

   always_comb begin
      for (int s = 0; s < NSLOT; s++) begin
         logic hit;
         if (s < NUM_ARCH)
            hit = upd_en && upd_dst_vld && (upd_dst == ARCH_W'(s));
         else if (s == C_SLOT)
            hit = upd_en && upd_flags[FW_CARRY];
         else
            hit = upd_en && upd_flags[FW_REST];
         if (hit)
            nxt_img[s] = upd_tag;
         else if (load_en)
            nxt_img[s] = load_img[s];
         else
            nxt_img[s] = img[s];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int s = 0; s < NSLOT; s++)
            img[s] <= (s < NUM_ARCH) ? TAG_W'(s) : '0;
      end else begin
         img <= nxt_img;
      end
   end
endmodule

// File: rtl/frt_ref_decode.sv
module frt_ref_decode #(
   parameter int NSLOT    = 10,
   parameter int NUM_PHYS = 32,
   parameter int TAG_W    = $clog2(NUM_PHYS)
) (
   input  logic [NSLOT-1:0][TAG_W-1:0] img,
   output logic [NUM_PHYS-1:0]         used
);
   always_comb begin
      used = '0;
      for (int s = 0; s < NSLOT; s++)
         used[img[s]] = 1'b1;
   end
endmodule

// File: rtl/frt_free_pick.sv
module frt_free_pick #(
   parameter int NUM_PHYS = 32,
   parameter int TAG_W    = $clog2(NUM_PHYS)
) (
   input  logic [NUM_PHYS-1:0] busy,
   output logic                any_free,
   output logic [TAG_W-1:0]    pick_tag
);
   always_comb begin
      any_free = 1'b0;
      pick_tag = '0;
      for (int i = NUM_PHYS - 1; i >= 0; i--) begin
         if (!busy[i]) begin
            any_free = 1'b1;
            pick_tag = TAG_W'(i);
         end
      end
   end
endmodule

// File: rtl/flag_rename_table.sv
module flag_rename_table
   import frt_pkg::*;
#(
   parameter int NUM_ARCH = 8,
   parameter int NUM_PHYS = 32,
   parameter int ARCH_W   = $clog2(NUM_ARCH),
   parameter int TAG_W    = $clog2(NUM_PHYS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              ren_valid,
   input  logic [ARCH_W-1:0] ren_src0,
   input  logic [ARCH_W-1:0] ren_src1,
   input  logic              ren_dst_vld,
   input  logic [ARCH_W-1:0] ren_dst,
   input  logic [1:0]        ren_flag_wr,
   output logic              ren_ready,
   output logic              ren_alloc,
   output logic [TAG_W-1:0]  ren_src0_tag,
   output logic [TAG_W-1:0]  ren_src1_tag,
   output logic [TAG_W-1:0]  ren_carry_tag,
   output logic [TAG_W-1:0]  ren_rest_tag,
   output logic [TAG_W-1:0]  ren_new_tag,
   input  logic              cmt_valid,
   input  logic              cmt_dst_vld,
   input  logic [ARCH_W-1:0] cmt_dst,
   input  logic [1:0]        cmt_flag_wr,
   input  logic [TAG_W-1:0]  cmt_tag
);
   localparam int NSLOT  = NUM_ARCH + 2;
   localparam int C_SLOT = NUM_ARCH;
   localparam int R_SLOT = NUM_ARCH + 1;

   generate
      if (NUM_PHYS <= NUM_ARCH) begin : g_bad_phys
         $error("NUM_PHYS must exceed NUM_ARCH");
      end
      if (NUM_ARCH < 2 || (1 << ARCH_W) < NUM_ARCH) begin : g_bad_arch
         $error("NUM_ARCH too small or ARCH_W too narrow");
      end
      if ((1 << TAG_W) < NUM_PHYS) begin : g_bad_tag
         $error("TAG_W too narrow for NUM_PHYS");
      end
   endgenerate

   logic [NSLOT-1:0][TAG_W-1:0] spec_img;
   logic [NSLOT-1:0][TAG_W-1:0] cmt_img;
   logic [NUM_PHYS-1:0]         cmt_used;
   logic [NUM_PHYS-1:0]         inflight;
   logic                        any_free;
   logic [TAG_W-1:0]            pick_tag;
   logic                        needs_tag;

   // Speculative write port: rename normally, the retiring op during a flush.
   logic              s_upd_en;
   logic              s_upd_dst_vld;
   logic [ARCH_W-1:0] s_upd_dst;
   logic [1:0]        s_upd_flags;
   logic [TAG_W-1:0]  s_upd_tag;

   assign needs_tag = ren_dst_vld || (ren_flag_wr != FW_NONE);
   assign ren_ready = !flush && (!needs_tag || any_free);
   assign ren_alloc = ren_valid && ren_ready && needs_tag;
   assign ren_new_tag = pick_tag;

   assign ren_src0_tag  = spec_img[ren_src0];
   assign ren_src1_tag  = spec_img[ren_src1];
   assign ren_carry_tag = spec_img[C_SLOT];
   assign ren_rest_tag  = spec_img[R_SLOT];

   always_comb begin
      if (flush) begin
         s_upd_en      = cmt_valid;
         s_upd_dst_vld = cmt_dst_vld;
         s_upd_dst     = cmt_dst;
         s_upd_flags   = cmt_flag_wr;
         s_upd_tag     = cmt_tag;
      end else begin
         s_upd_en      = ren_alloc;
         s_upd_dst_vld = ren_dst_vld;
         s_upd_dst     = ren_dst;
         s_upd_flags   = ren_flag_wr;
         s_upd_tag     = pick_tag;
      end
   end

   frt_alias_state #(
      .NUM_ARCH (NUM_ARCH),
      .TAG_W    (TAG_W),
      .ARCH_W   (ARCH_W),
      .NSLOT    (NSLOT)
   ) u_spec (
      .clk         (clk),
      .rst_n       (rst_n),
      .upd_en      (s_upd_en),
      .upd_dst_vld (s_upd_dst_vld),
      .upd_dst     (s_upd_dst),
      .upd_flags   (s_upd_flags),
      .upd_tag     (s_upd_tag),
      .load_en     (flush),
      .load_img    (cmt_img),
      .img         (spec_img)
   );

   frt_alias_state #(
      .NUM_ARCH (NUM_ARCH),
      .TAG_W    (TAG_W),
      .ARCH_W   (ARCH_W),
      .NSLOT    (NSLOT)
   ) u_commit (
      .clk         (clk),
      .rst_n       (rst_n),
      .upd_en      (cmt_valid),
      .upd_dst_vld (cmt_dst_vld),
      .upd_dst     (cmt_dst),
      .upd_flags   (cmt_flag_wr),
      .upd_tag     (cmt_tag),
      .load_en     (1'b0),
      .load_img    ('0),
      .img         (cmt_img)
   );

   frt_ref_decode #(
      .NSLOT    (NSLOT),
      .NUM_PHYS (NUM_PHYS),
      .TAG_W    (TAG_W)
   ) u_cmt_ref (
      .img  (cmt_img),
      .used (cmt_used)
   );

   frt_free_pick #(
      .NUM_PHYS (NUM_PHYS),
      .TAG_W    (TAG_W)
   ) u_pick (
      .busy     (inflight | cmt_used),
      .any_free (any_free),
      .pick_tag (pick_tag)
   );

   always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
         inflight <= '0;
      end else begin
         for (int p = 0; p < NUM_PHYS; p++) begin
            if (ren_alloc && pick_tag == TAG_W'(p))
               inflight[p] <= 1'b1;
            else if (cmt_valid && cmt_tag == TAG_W'(p))
               inflight[p] <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/frt_checker.sv
module frt_checker #(
   parameter int NUM_ARCH = 8,
   parameter int NUM_PHYS = 32,
   parameter int ARCH_W   = $clog2(NUM_ARCH),
   parameter int TAG_W    = $clog2(NUM_PHYS),
   parameter int NSLOT    = NUM_ARCH + 2
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic                        flush,
   input logic                        ren_valid,
   input logic                        ren_ready,
   input logic                        ren_alloc,
   input logic                        ren_dst_vld,
   input logic [ARCH_W-1:0]           ren_dst,
   input logic [1:0]                  ren_flag_wr,
   input logic [TAG_W-1:0]            ren_new_tag,
   input logic                        cmt_valid,
   input logic                        cmt_dst_vld,
   input logic [ARCH_W-1:0]           cmt_dst,
   input logic [TAG_W-1:0]            cmt_tag,
   input logic [NSLOT-1:0][TAG_W-1:0] spec_img,
   input logic [NSLOT-1:0][TAG_W-1:0] cmt_img,
   input logic [NUM_PHYS-1:0]         inflight,
   input logic [NUM_PHYS-1:0]         cmt_used
);
   p_alloc_handshake_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ren_alloc |-> (ren_valid && ren_ready));

   p_dst_takes_tag_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (ren_alloc && ren_dst_vld) |=> spec_img[$past(ren_dst)] == $past(ren_new_tag));

   p_carry_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (ren_alloc && !ren_flag_wr[1]) |=> $stable(spec_img[NUM_ARCH]));

   p_stall_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!ren_ready && !flush) |=> $stable(spec_img));

   p_tag_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ren_alloc |-> (!inflight[ren_new_tag] && !cmt_used[ren_new_tag]));

   p_commit_map_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (cmt_valid && cmt_dst_vld) |=> cmt_img[$past(cmt_dst)] == $past(cmt_tag));

   p_flush_block_r9: assert property (@(posedge clk) disable iff (!rst_n)
      flush |-> !ren_ready);

   p_flush_copy_r9: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (spec_img == cmt_img && inflight == '0));
endmodule

bind flag_rename_table frt_checker #(
   .NUM_ARCH (NUM_ARCH),
   .NUM_PHYS (NUM_PHYS),
   .ARCH_W   (ARCH_W),
   .TAG_W    (TAG_W),
   .NSLOT    (NSLOT)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .flush       (flush),
   .ren_valid   (ren_valid),
   .ren_ready   (ren_ready),
   .ren_alloc   (ren_alloc),
   .ren_dst_vld (ren_dst_vld),
   .ren_dst     (ren_dst),
   .ren_flag_wr (ren_flag_wr),
   .ren_new_tag (ren_new_tag),
   .cmt_valid   (cmt_valid),
   .cmt_dst_vld (cmt_dst_vld),
   .cmt_dst     (cmt_dst),
   .cmt_tag     (cmt_tag),
   .spec_img    (spec_img),
   .cmt_img     (cmt_img),
   .inflight    (inflight),
   .cmt_used    (cmt_used)
);

// File: tb/flag_rename_table_tb_top.sv
module flag_rename_table_tb_top;
   localparam int NA = 8;
   localparam int NP = 32;
   localparam int NS = NA + 2;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       flush = 1'b0;
   logic       ren_valid = 1'b0;
   logic [2:0] ren_src0 = '0, ren_src1 = '0, ren_dst = '0;
   logic       ren_dst_vld = 1'b0;
   logic [1:0] ren_flag_wr = '0;
   logic       ren_ready, ren_alloc;
   logic [4:0] ren_src0_tag, ren_src1_tag, ren_carry_tag, ren_rest_tag, ren_new_tag;
   logic       cmt_valid = 1'b0, cmt_dst_vld = 1'b0;
   logic [2:0] cmt_dst = '0;
   logic [1:0] cmt_flag_wr = '0;
   logic [4:0] cmt_tag = '0;

   always #10 clk = ~clk;

   flag_rename_table dut_i (
      .clk(clk), .rst_n(rst_n), .flush(flush),
      .ren_valid(ren_valid), .ren_src0(ren_src0), .ren_src1(ren_src1),
      .ren_dst_vld(ren_dst_vld), .ren_dst(ren_dst), .ren_flag_wr(ren_flag_wr),
      .ren_ready(ren_ready), .ren_alloc(ren_alloc),
      .ren_src0_tag(ren_src0_tag), .ren_src1_tag(ren_src1_tag),
      .ren_carry_tag(ren_carry_tag), .ren_rest_tag(ren_rest_tag),
      .ren_new_tag(ren_new_tag),
      .cmt_valid(cmt_valid), .cmt_dst_vld(cmt_dst_vld), .cmt_dst(cmt_dst),
      .cmt_flag_wr(cmt_flag_wr), .cmt_tag(cmt_tag)
   );

   typedef struct { bit dv; int d; int fm; int tag; } op_t;

   int  n_chk = 0;
   int  n_bad = 0;
   int  sp[NS];
   int  cm[NS];
   bit  infl[NP];
   op_t q[$];

   task automatic chk(string lbl, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", lbl, act, exp);
      end
   endtask

   function automatic int model_pick();
      for (int p = 0; p < NP; p++) begin
         bit used = infl[p];
         for (int s = 0; s < NS; s++) if (cm[s] == p) used = 1'b1;
         if (!used) return p;
      end
      return -1;
   endfunction

   function automatic void apply(ref int img[NS], input bit dv, int d, int fm, int tag);
      if (dv) img[d] = tag;
      if (fm[1]) img[NA] = tag;
      if (fm[0]) img[NA+1] = tag;
   endfunction

   // One cycle: drive, compare combinational outputs, then advance the model.
   task automatic step(bit v, int s0, int s1, bit dv, int d, int fm, bit cv_req, bit fl);
      bit   need, exp_rdy, exp_alloc, cv;
      int   pk;
      op_t  h;
      @(negedge clk);
      cv = cv_req && (q.size() > 0);
      if (cv) h = q[0];
      ren_valid = v; ren_src0 = 3'(s0); ren_src1 = 3'(s1);
      ren_dst_vld = dv; ren_dst = 3'(d); ren_flag_wr = 2'(fm);
      flush = fl; cmt_valid = cv;
      cmt_dst_vld = cv ? h.dv : 1'b0; cmt_dst = cv ? 3'(h.d) : '0;
      cmt_flag_wr = cv ? 2'(h.fm) : '0; cmt_tag = cv ? 5'(h.tag) : '0;
      #1;
      need = dv || (fm != 0);
      pk = model_pick();
      exp_rdy = !fl && (!need || pk >= 0);
      exp_alloc = v && exp_rdy && need;
      chk("R6 ready", int'(ren_ready), int'(exp_rdy));
      chk("R5 alloc", int'(ren_alloc), int'(exp_alloc));
      chk("R2 src0", int'(ren_src0_tag), sp[s0]);
      chk("R2 src1", int'(ren_src1_tag), sp[s1]);
      chk("R4 carry", int'(ren_carry_tag), sp[NA]);
      chk("R4 rest", int'(ren_rest_tag), sp[NA+1]);
      if (exp_alloc) chk("R3/R7 new tag", int'(ren_new_tag), pk);
      @(posedge clk);
      if (cv) begin
         apply(cm, h.dv, h.d, h.fm, h.tag);
         infl[h.tag] = 1'b0;
         void'(q.pop_front());
      end
      if (exp_alloc) begin
         op_t o;
         o.dv = dv; o.d = d; o.fm = fm; o.tag = pk;
         apply(sp, dv, d, fm, pk);
         infl[pk] = 1'b1;
         q.push_back(o);
      end
      if (fl) begin
         sp = cm;
         for (int p = 0; p < NP; p++) infl[p] = 1'b0;
         q.delete();
      end
   endtask

   task automatic peek(int s, int e_src, int e_c, int e_r, string lbl);
      @(negedge clk);
      ren_valid = 1'b0; flush = 1'b0; cmt_valid = 1'b0; ren_src0 = 3'(s);
      #1;
      chk({lbl, " src"}, int'(ren_src0_tag), e_src);
      chk({lbl, " carry"}, int'(ren_carry_tag), e_c);
      chk({lbl, " rest"}, int'(ren_rest_tag), e_r);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_bad++; n_chk++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      for (int s = 0; s < NS; s++) begin
         sp[s] = (s < NA) ? s : 0;
         cm[s] = sp[s];
      end
      for (int p = 0; p < NP; p++) infl[p] = 1'b0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1: reset mapping
      for (int i = 0; i < NA; i++) peek(i, i, 0, 0, "R1");

      // R3: full-flag writer to r3 takes tag 8 for register and both groups
      step(1, 0, 0, 1, 3, 3, 0, 0);
      peek(3, 8, 8, 8, "R3");
      // R4: partial writer (others only) leaves carry at 8
      step(1, 3, 0, 1, 4, 1, 0, 0);
      peek(4, 9, 8, 9, "R4");
      // R4: carry-only writer, no destination
      step(1, 0, 0, 0, 0, 2, 0, 0);
      peek(0, 0, 10, 9, "R4");
      // R5: no destination, no flags
      step(1, 1, 2, 0, 0, 0, 0, 0);
      peek(0, 0, 10, 9, "R5");
      // R6: exhaust the pool (tags 11..31), then stall
      for (int i = 0; i < 21; i++) step(1, 0, 0, 1, 5, 0, 0, 0);
      step(1, 0, 0, 1, 6, 0, 0, 0);
      peek(5, 31, 10, 9, "R6");
      // R8: commit r3<-8 frees tag 3 only from the next cycle
      step(1, 0, 0, 1, 6, 0, 1, 0);
      step(1, 0, 0, 1, 6, 0, 0, 0);
      peek(6, 3, 10, 9, "R8");
      // R9: flush with a same-cycle commit of r4<-9 (others group)
      step(1, 0, 0, 1, 7, 3, 1, 1);
      peek(5, 5, 8, 9, "R9");
      peek(4, 9, 8, 9, "R9");
      peek(6, 6, 8, 9, "R9");
      step(1, 0, 0, 1, 1, 0, 0, 0);
      peek(1, 3, 8, 9, "R9");

      // Constrained random phase
      void'($urandom(32'h1f2e3d4c));
      for (int i = 0; i < 600; i++) begin
         bit v  = ($urandom % 10) < 8;
         bit dv = ($urandom % 10) < 7;
         int fm = $urandom % 4;
         bit cv = ($urandom % 10) < 5;
         bit fl = ($urandom % 100) < 3;
         step(v, $urandom % NA, $urandom % NA, dv, $urandom % NA, fm, cv, fl);
      end
      // Drain and verify the committed state by flushing
      for (int i = 0; i < 40; i++) step(0, 0, 0, 0, 0, 0, 1, 0);
      step(0, 0, 0, 0, 0, 0, 0, 1);
      for (int i = 0; i < NA; i++) peek(i, cm[i], cm[NA], cm[NA+1], "R9 drained");

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule